// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Self-Refresh Control

This block keeps a fast-page-mode DRAM's contents alive. It sits beside the access sequencer and shares the RAS#/CAS#/WE# strobes with it through a request/grant pair. After reset it waits out a power-up pause. It then runs a fixed number of wake-up refresh cycles and only afterwards reports that normal accesses may start. In steady state an interval timer adds one owed refresh to a backlog counter every pacing period. Each owed refresh is paid back with one CAS-before-RAS cycle once the sequencer grants the strobes.

The sequencer may postpone refreshes while it is busy. When the backlog reaches a set level, the request is flagged as urgent. If the backlog sits at its hard limit when another pacing tick arrives, the retention window is taken as lost. The block then reloads the backlog with the wake-up count and blocks accesses until that sequence has run again.

A level input asks for self refresh. The block starts a CBR cycle and holds RAS low for the minimum self-refresh entry time, then reports that the DRAM is in self refresh. When the level drops, it raises both strobes, keeps them high and owned for the exit hold time, and then releases them. With the default distributed policy no catch-up is owed after exit. A parameter selects a burst policy instead, which refreshes a full set of rows before accesses resume. All times are counted in clock cycles and set by parameters.

Top module: `dram_refresh_sched`

## Requirements
- R1: For PAUSE_CYC cycles after reset release, req, own and ready stay low and the strobes stay high (ras_n=1, cas_n=1, we_n=1).
- R2: After the pause exactly WAKE_COUNT refresh cycles run before ready rises; we_n stays 1 throughout.
- R3: Every refresh cycle holds cas_n low with ras_n high for CAS_LEAD_CYC cycles, then holds both low for RAS_LOW_CYC cycles, then holds both high with own still 1 for PRECHARGE_CYC cycles.
- R4: Once ready, one refresh is owed every PACE_CYC cycles; with grant always given, exactly one refresh cycle starts per pacing period.
- R5: req stays high and own stays low while gnt is low; own rises only in the cycle after req and gnt were both high.
- R6: urgent is high exactly while the backlog is at or above URGENT_LEVEL, and it falls once the backlog has been worked off.
- R7: A pacing tick that finds the backlog at BACKLOG_LIMIT drops ready and reloads the backlog with WAKE_COUNT. Ready returns only after those refresh cycles complete, and pacing is frozen meanwhile.
- R8: sr_req high (outside wake-up) leads, after a grant, to a CBR start whose RAS-low phase lasts SELF_HOLD_CYC cycles before in_self rises. While in_self is high both strobes stay low, the backlog is cleared and no request is raised.
- R9: When sr_req falls, in_self drops in the next cycle and both strobes are held high with own high for EXIT_HOLD_CYC cycles. Then ready returns with no catch-up refresh, and the next request comes one full pacing period later.
- R10: sr_req has no effect during a wake-up sequence: granted cycles there are ordinary refreshes and in_self stays low.
- R11: With BURST_EXIT=1, leaving self refresh keeps ready low until BURST_ROWS refresh cycles have run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all parameter times are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| gnt | input | 1 | Strobe grant from the access sequencer |
| sr_req | input | 1 | Level request to enter (high) or leave (low) self refresh |
| req | output | 1 | Request for the strobes |
| urgent | output | 1 | Backlog at or above the urgency level |
| own | output | 1 | Block is driving the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low (kept high for refresh) |
| in_self | output | 1 | DRAM is in self refresh |
| ready | output | 1 | Normal accesses are permitted |

## Verification
The assertions assume the sequencer follows the handshake. It raises gnt only in answer to req and never fights the strobes while own is high. They also assume sr_req does not toggle during the entry hold in a way that matters, since the block samples it only at decision points. The stimulus holds gnt either constantly high or constantly low for whole phases, so every grant answers a pending request. It changes sr_req only when the block is idle, waiting, in self refresh or in wake-up, and starves the grant only long enough to reach the urgency level or exactly one lapse.

// File: rtl/dram_rfs_pkg.sv
package dram_rfs_pkg;

    typedef enum logic [3:0] {
        RS_PAUSE,
        RS_IDLE,
        RS_ASK,
        RS_CASLEAD,
        RS_RASLOW,
        RS_PRECH,
        RS_SRHOLD,
        RS_SELF,
        RS_SREXIT
    } rfs_state_e;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_rfs_timer.sv
module dram_rfs_timer #(
    parameter int unsigned INTERVAL = 3125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t d, q;

    always_comb begin
        d    = q;
        tick = run && (q.cnt == TW'(INTERVAL - 1));
        if (!run) begin
            d.cnt = '0;
        end else if (tick) begin
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    generate
        if (INTERVAL > 1) begin : g_gap
            // R4: two owed refreshes never arrive back to back
            p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/dram_rfs_backlog.sv
module dram_rfs_backlog #(
    parameter int unsigned WAKE_COUNT    = 8,
    parameter int unsigned URGENT_LEVEL  = 4,
    parameter int unsigned BACKLOG_LIMIT = 8,
    parameter bit          BURST_EXIT    = 1'b0,
    parameter int unsigned BURST_ROWS    = 4096,
    parameter int unsigned CW            = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          done,
    input  logic          load_wake,
    input  logic          clear,
    input  logic          reload,
    output logic [CW-1:0] pend,
    output logic          urgent,
    output logic          lapse
);
    localparam logic [CW-1:0] WAKE_V   = CW'(WAKE_COUNT);
    localparam logic [CW-1:0] LIMIT_V  = CW'(BACKLOG_LIMIT);
    localparam logic [CW-1:0] URGENT_V = CW'(URGENT_LEVEL);
    localparam logic [CW-1:0] RELOAD_V = BURST_EXIT ? CW'(BURST_ROWS) : '0;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } blg_t;

    blg_t d, q;

    always_comb begin
        d      = q;
        lapse  = tick && (q.cnt == LIMIT_V) && !load_wake && !clear;
        if (load_wake) begin
            d.cnt = WAKE_V;
        end else if (clear) begin
            d.cnt = '0;
        end else if (reload) begin
            d.cnt = RELOAD_V;
        end else if (lapse) begin
            d.cnt = WAKE_V;
        end else if (tick && !done) begin
            d.cnt = q.cnt + CW'(1);
        end else if (done && !tick) begin
            d.cnt = q.cnt - CW'(1);
        end
        pend   = q.cnt;
        urgent = (q.cnt >= URGENT_V);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R7: a lapse restarts the owed count at the wake-up length
    p_lapse_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lapse |=> (pend == WAKE_V));

    // R4: a finished refresh with nothing else happening pays off exactly one
    p_drain_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !tick && !clear && !reload && !load_wake) |=> (pend == $past(pend) - CW'(1)));

    // R6: urgency only appears after a pacing tick or a reload of the count
    p_urgent_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(urgent) |-> ($past(tick) || $past(load_wake) || $past(reload)));

endmodule

// File: rtl/dram_rfs_seq.sv
module dram_rfs_seq
    import dram_rfs_pkg::*;
#(
    parameter int unsigned PAUSE_CYC     = 20000,
    parameter int unsigned CAS_LEAD_CYC  = 1,
    parameter int unsigned RAS_LOW_CYC   = 12,
    parameter int unsigned PRECHARGE_CYC = 8,
    parameter int unsigned SELF_HOLD_CYC = 20000,
    parameter int unsigned EXIT_HOLD_CYC = 21,
    parameter bit          BURST_EXIT    = 1'b0,
    parameter int unsigned PW            = 15,
    parameter int unsigned CW            = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gnt,
    input  logic          sr_req,
    input  logic [CW-1:0] pend,
    input  logic          lapse,
    output logic          load_wake,
    output logic          done,
    output logic          sr_enter,
    output logic          sr_leave,
    output logic          run,
    output logic          req,
    output logic          own,
    output logic          ras_n,
    output logic          cas_n,
    output logic          we_n,
    output logic          in_self,
    output logic          ready
);
    typedef struct packed {
        rfs_state_e    st;
        logic [PW-1:0] cnt;
        logic          wake;
        logic          sel;
    } seq_t;

    seq_t d, q;
    logic need;

    always_comb begin
        d         = q;
        load_wake = 1'b0;
        done      = 1'b0;
        sr_enter  = 1'b0;
        sr_leave  = 1'b0;
        need      = (pend != '0) || (sr_req && !q.wake);
        case (q.st)
            RS_PAUSE: begin
                if (q.cnt == PW'(PAUSE_CYC - 1)) begin
                    d.st      = RS_IDLE;
                    d.cnt     = '0;
                    d.wake    = 1'b1;
                    load_wake = 1'b1;
                end else begin
                    d.cnt = q.cnt + PW'(1);
                end
            end
            RS_IDLE: begin
                if (need) begin
                    d.st = RS_ASK;
                end
            end
            RS_ASK: begin
                if (!need) begin
                    d.st = RS_IDLE;
                end else if (gnt) begin
                    d.st  = RS_CASLEAD;
                    d.cnt = '0;
                    d.sel = sr_req && !q.wake;
                end
            end
            RS_CASLEAD: begin
                if (q.cnt == PW'(CAS_LEAD_CYC - 1)) begin
                    d.cnt = '0;
                    if (q.sel) begin
                        d.st     = RS_SRHOLD;
                        sr_enter = 1'b1;
                    end else begin
                        d.st = RS_RASLOW;
                    end
                end else begin
                    d.cnt = q.cnt + PW'(1);
                end
            end
            RS_RASLOW: begin
                if (q.cnt == PW'(RAS_LOW_CYC - 1)) begin
                    d.st  = RS_PRECH;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + PW'(1);
                end
            end
            RS_PRECH: begin
                if (q.cnt == PW'(PRECHARGE_CYC - 1)) begin
                    d.st  = RS_IDLE;
                    d.cnt = '0;
                    done  = 1'b1;
                    if (pend == CW'(1)) begin
                        d.wake = 1'b0;
                    end
                end else begin
                    d.cnt = q.cnt + PW'(1);
                end
            end
            RS_SRHOLD: begin
                if (q.cnt == PW'(SELF_HOLD_CYC - 1)) begin
                    d.st  = RS_SELF;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + PW'(1);
                end
            end
            RS_SELF: begin
                if (!sr_req) begin
                    d.st  = RS_SREXIT;
                    d.cnt = '0;
                end
            end
            RS_SREXIT: begin
                if (q.cnt == PW'(EXIT_HOLD_CYC - 1)) begin
                    d.st     = RS_IDLE;
                    d.cnt    = '0;
                    d.wake   = BURST_EXIT;
                    sr_leave = 1'b1;
                end else begin
                    d.cnt = q.cnt + PW'(1);
                end
            end
            default: begin
                d.st = RS_IDLE;
            end
        endcase
        if (lapse) begin
            d.wake = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= RS_PAUSE;
            q.cnt  <= '0;
            q.wake <= 1'b0;
            q.sel  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    logic sr_phase;

    always_comb begin
        sr_phase = (q.st == RS_SRHOLD) || (q.st == RS_SELF) || (q.st == RS_SREXIT);
        run      = !q.wake && ((q.st == RS_IDLE) || (q.st == RS_ASK) || (q.st == RS_CASLEAD)
                               || (q.st == RS_RASLOW) || (q.st == RS_PRECH));
        req      = (q.st == RS_ASK);
        own      = (q.st == RS_CASLEAD) || (q.st == RS_RASLOW) || (q.st == RS_PRECH) || sr_phase;
        cas_n    = !((q.st == RS_CASLEAD) || (q.st == RS_RASLOW)
                     || (q.st == RS_SRHOLD) || (q.st == RS_SELF));
        ras_n    = !((q.st == RS_RASLOW) || (q.st == RS_SRHOLD) || (q.st == RS_SELF));
        we_n     = 1'b1;
        in_self  = (q.st == RS_SELF);
        ready    = (q.st != RS_PAUSE) && !q.wake && !sr_phase;
    end

    // R3: RAS only ever falls with CAS already low (CBR order)
    p_cas_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(!cas_n));

    // R3: no RAS-only cycle is ever produced
    p_ras_needs_cas_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n);

    // R5: strobes are taken only after a granted request
    p_grant_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(own) |-> $past(req && gnt));

    // R2: accesses open only at the end of an owned strobe phase
    p_ready_after_own_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(own));

    // R8: self refresh keeps both strobes low
    p_self_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_self |-> (!ras_n && !cas_n));

    // R9: leaving self refresh raises RAS while still owning the strobes
    p_exit_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_self) |-> (own && ras_n && cas_n));

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import dram_rfs_pkg::*;
#(
    parameter int unsigned PAUSE_CYC     = 20000,
    parameter int unsigned PACE_CYC      = 3125,
    parameter int unsigned CAS_LEAD_CYC  = 1,
    parameter int unsigned RAS_LOW_CYC   = 12,
    parameter int unsigned PRECHARGE_CYC = 8,
    parameter int unsigned SELF_HOLD_CYC = 20000,
    parameter int unsigned EXIT_HOLD_CYC = 21,
    parameter int unsigned WAKE_COUNT    = 8,
    parameter int unsigned URGENT_LEVEL  = 4,
    parameter int unsigned BACKLOG_LIMIT = 8,
    parameter bit          BURST_EXIT    = 1'b0,
    parameter int unsigned BURST_ROWS    = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gnt,
    input  logic sr_req,
    output logic req,
    output logic urgent,
    output logic own,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic in_self,
    output logic ready
);
    localparam int unsigned PH_MAX = umax(umax(PAUSE_CYC, SELF_HOLD_CYC),
                                          umax(umax(CAS_LEAD_CYC, RAS_LOW_CYC),
                                               umax(PRECHARGE_CYC, EXIT_HOLD_CYC)));
    localparam int unsigned PW     = $clog2(PH_MAX + 1);
    localparam int unsigned CNT_MAX = umax(umax(WAKE_COUNT, BACKLOG_LIMIT), BURST_ROWS);
    localparam int unsigned CW     = $clog2(CNT_MAX + 1);

    logic          tick;
    logic          run;
    logic          lapse;
    logic          load_wake;
    logic          done;
    logic          sr_enter;
    logic          sr_leave;
    logic [CW-1:0] pend;

    dram_rfs_timer #(
        .INTERVAL (PACE_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    dram_rfs_backlog #(
        .WAKE_COUNT    (WAKE_COUNT),
        .URGENT_LEVEL  (URGENT_LEVEL),
        .BACKLOG_LIMIT (BACKLOG_LIMIT),
        .BURST_EXIT    (BURST_EXIT),
        .BURST_ROWS    (BURST_ROWS),
        .CW            (CW)
    ) u_backlog (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .done      (done),
        .load_wake (load_wake),
        .clear     (sr_enter),
        .reload    (sr_leave),
        .pend      (pend),
        .urgent    (urgent),
        .lapse     (lapse)
    );

    dram_rfs_seq #(
        .PAUSE_CYC     (PAUSE_CYC),
        .CAS_LEAD_CYC  (CAS_LEAD_CYC),
        .RAS_LOW_CYC   (RAS_LOW_CYC),
        .PRECHARGE_CYC (PRECHARGE_CYC),
        .SELF_HOLD_CYC (SELF_HOLD_CYC),
        .EXIT_HOLD_CYC (EXIT_HOLD_CYC),
        .BURST_EXIT    (BURST_EXIT),
        .PW            (PW),
        .CW            (CW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .gnt       (gnt),
        .sr_req    (sr_req),
        .pend      (pend),
        .lapse     (lapse),
        .load_wake (load_wake),
        .done      (done),
        .sr_enter  (sr_enter),
        .sr_leave  (sr_leave),
        .run       (run),
        .req       (req),
        .own       (own),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .in_self   (in_self),
        .ready     (ready)
    );

endmodule

// File: tb/dram_refresh_sched_bench.sv
`timescale 1ns/1ps
module dram_refresh_sched_bench;

    localparam int P_PAUSE = 40;
    localparam int P_INT   = 60;
    localparam int P_LEAD  = 2;
    localparam int P_RAS   = 12;
    localparam int P_PRE   = 8;
    localparam int P_HOLD  = 50;
    localparam int P_EXIT  = 21;
    localparam int P_WAKE  = 8;
    localparam int P_URG   = 4;
    localparam int P_LIM   = 6;
    localparam int P_BROWS = 5;

    logic clk = 1'b0;
    logic rst_n;
    logic gnt, sr_req;
    logic req, urgent, own, ras_n, cas_n, we_n, in_self, ready;
    logic gnt_b, sr_req_b;
    logic req_b, urgent_b, own_b, ras_b, cas_b, we_b, in_self_b, ready_b;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dram_refresh_sched #(
        .PAUSE_CYC(P_PAUSE), .PACE_CYC(P_INT), .CAS_LEAD_CYC(P_LEAD), .RAS_LOW_CYC(P_RAS),
        .PRECHARGE_CYC(P_PRE), .SELF_HOLD_CYC(P_HOLD), .EXIT_HOLD_CYC(P_EXIT),
        .WAKE_COUNT(P_WAKE), .URGENT_LEVEL(P_URG), .BACKLOG_LIMIT(P_LIM),
        .BURST_EXIT(1'b0), .BURST_ROWS(P_BROWS)
    ) u_dram_refresh_sched (
        .clk(clk), .rst_n(rst_n), .gnt(gnt), .sr_req(sr_req), .req(req), .urgent(urgent),
        .own(own), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .in_self(in_self), .ready(ready)
    );

    dram_refresh_sched #(
        .PAUSE_CYC(P_PAUSE), .PACE_CYC(P_INT), .CAS_LEAD_CYC(P_LEAD), .RAS_LOW_CYC(P_RAS),
        .PRECHARGE_CYC(P_PRE), .SELF_HOLD_CYC(P_HOLD), .EXIT_HOLD_CYC(P_EXIT),
        .WAKE_COUNT(P_WAKE), .URGENT_LEVEL(P_URG), .BACKLOG_LIMIT(P_LIM),
        .BURST_EXIT(1'b1), .BURST_ROWS(P_BROWS)
    ) u_dram_refresh_sched_burst (
        .clk(clk), .rst_n(rst_n), .gnt(gnt_b), .sr_req(sr_req_b), .req(req_b), .urgent(urgent_b),
        .own(own_b), .ras_n(ras_b), .cas_n(cas_b), .we_n(we_b), .in_self(in_self_b), .ready(ready_b)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // ---------------- behavioural reference (countdown phases) ----------------
    // phase: 0 pause, 1 idle, 2 asking, 3 cas lead, 4 ras low, 5 precharge,
    //        6 self entry hold, 7 self refresh, 8 self exit hold
    int m_ph, m_left, m_pend, m_tmr;
    bit m_wk, m_sel;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_left = P_PAUSE; m_pend = 0; m_tmr = 0; m_wk = 0; m_sel = 0;
        end else begin
            bit need, running, tick, lapse, f_load, f_clear, f_done;
            need    = (m_pend != 0) || (sr_req && !m_wk);
            running = (m_ph >= 1) && (m_ph <= 5) && !m_wk;
            tick    = running && (m_tmr == P_INT - 1);
            m_tmr   = running ? (tick ? 0 : m_tmr + 1) : 0;
            f_load = 0; f_clear = 0; f_done = 0;
            lapse  = tick && (m_pend == P_LIM);
            case (m_ph)
                0: if (m_left == 1) begin m_ph = 1; m_wk = 1; f_load = 1; end else m_left--;
                1: if (need) m_ph = 2;
                2: if (!need) m_ph = 1;
                   else if (gnt) begin m_ph = 3; m_left = P_LEAD; m_sel = sr_req && !m_wk; end
                3: if (m_left == 1) begin
                       if (m_sel) begin m_ph = 6; m_left = P_HOLD; f_clear = 1; end
                       else begin m_ph = 4; m_left = P_RAS; end
                   end else m_left--;
                4: if (m_left == 1) begin m_ph = 5; m_left = P_PRE; end else m_left--;
                5: if (m_left == 1) begin
                       m_ph = 1; f_done = 1;
                       if (m_pend == 1) m_wk = 0;
                   end else m_left--;
                6: if (m_left == 1) m_ph = 7; else m_left--;
                7: if (!sr_req) begin m_ph = 8; m_left = P_EXIT; end
                8: if (m_left == 1) begin m_ph = 1; m_wk = 0; m_pend = 0; end else m_left--;
                default: m_ph = 1;
            endcase
            if (f_clear) lapse = 0;
            if (lapse) m_wk = 1;
            if (f_load) m_pend = P_WAKE;
            else if (f_clear) m_pend = 0;
            else if (lapse) m_pend = P_WAKE;
            else m_pend = m_pend + (tick ? 1 : 0) - (f_done ? 1 : 0);
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit e_cas, e_ras;
            e_cas = !(m_ph == 3 || m_ph == 4 || m_ph == 6 || m_ph == 7);
            e_ras = !(m_ph == 4 || m_ph == 6 || m_ph == 7);
            chk_eq("R3 ras_n vs model", int'(ras_n), int'(e_ras));
            chk_eq("R3 cas_n vs model", int'(cas_n), int'(e_cas));
            chk_eq("R2 we_n vs model", int'(we_n), 1);
            chk_eq("R5 own vs model", int'(own), int'(m_ph >= 3));
            chk_eq("R5 req vs model", int'(req), int'(m_ph == 2));
            chk_eq("R6 urgent vs model", int'(urgent), int'(m_pend >= P_URG));
            chk_eq("R8 in_self vs model", int'(in_self), int'(m_ph == 7));
            chk_eq("R4 ready vs model", int'(ready), int'(m_ph != 0 && !m_wk && m_ph < 6));
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: run did not end actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- directed scenario ----------------
    initial begin
        int n, lead, rasl, pre, quiet, hold, ex, self_seen;
        bit prev;
        gnt = 1'b1; sr_req = 1'b0; gnt_b = 1'b1; sr_req_b = 1'b0; rst_n = 1'b0;
        repeat (3) step();
        chk(ras_n && cas_n && we_n, "R1 strobes high in reset", int'(ras_n & cas_n), 1);
        chk(!own && !req && !ready && !in_self, "R1 outputs low in reset", int'(own | req | ready | in_self), 0);
        rst_n = 1'b1;

        quiet = 0;
        for (int i = 0; i < P_PAUSE; i++) begin
            step();
            if (req || own || ready || !ras_n || !cas_n) quiet++;
        end
        chk_eq("R1 quiet during pause", quiet, 0);

        // R3: shape of the first refresh cycle
        for (int g = 0; g < 100 && cas_n; g++) step();
        lead = 0; while (!cas_n && ras_n && lead < 100) begin lead++; step(); end
        rasl = 0; while (!ras_n && rasl < 100) begin rasl++; step(); end
        pre  = 0; while (own && ras_n && cas_n && pre < 100) begin pre++; step(); end
        chk_eq("R3 CAS lead cycles", lead, P_LEAD);
        chk_eq("R3 RAS low cycles", rasl, P_RAS);
        chk_eq("R3 precharge cycles", pre, P_PRE);

        // R2: wake-up count
        n = 1; prev = ras_n; ex = 0;
        for (int g = 0; g < 2000 && !ready; g++) begin
            step();
            if (prev && !ras_n) n++;
            if (!we_n) ex++;
            prev = ras_n;
        end
        chk_eq("R2 wake-up refresh count", n, P_WAKE);
        chk_eq("R2 we_n low cycles", ex, 0);
        chk_eq("R2 ready after wake-up", int'(ready), 1);

        // R4: one refresh per pacing period
        n = 0; prev = ras_n;
        repeat (5 * P_INT + 10) begin
            step();
            if (prev && !ras_n) n++;
            prev = ras_n;
        end
        chk_eq("R4 refreshes in five periods", n, 5);

        // R5/R6: starve the grant
        gnt = 1'b0;
        for (int g = 0; g < 100 && own; g++) step();
        ex = 0;
        repeat (4 * P_INT + 5) begin
            step();
            if (own) ex++;
        end
        chk_eq("R5 no ownership without grant", ex, 0);
        chk_eq("R5 request held", int'(req), 1);
        chk_eq("R6 urgent after postponed refreshes", int'(urgent), 1);
        gnt = 1'b1;
        for (int g = 0; g < 500 && urgent; g++) step();
        chk_eq("R6 urgent clears after drain", int'(urgent), 0);
        for (int g = 0; g < 200 && (own || req); g++) step();

        // R7: lapse
        gnt = 1'b0;
        for (int g = 0; g < 10 * P_INT && ready; g++) step();
        chk_eq("R7 lapse drops ready", int'(ready), 0);
        chk_eq("R7 reloaded backlog is urgent", int'(urgent), 1);

        // R10: self refresh request during wake-up is ignored
        sr_req = 1'b1; gnt = 1'b1;
        n = 0; self_seen = 0; prev = ras_n;
        for (int g = 0; g < 2000 && !ready; g++) begin
            step();
            if (prev && !ras_n) n++;
            if (in_self) self_seen++;
            prev = ras_n;
        end
        chk_eq("R7 repeated wake-up count", n, P_WAKE);
        chk_eq("R10 no self refresh during wake-up", self_seen, 0);

        // R8: entry
        for (int g = 0; g < 200 && ras_n; g++) step();
        hold = 0;
        while (!ras_n && !in_self && hold < 1000) begin hold++; step(); end
        chk_eq("R8 RAS low before self refresh", hold, P_HOLD);
        chk_eq("R8 in_self raised", int'(in_self), 1);
        ex = 0;
        repeat (3 * P_INT) begin
            step();
            if (req || !in_self || ras_n || cas_n) ex++;
        end
        chk_eq("R8 held quiet in self refresh", ex, 0);

        // R9: exit
        sr_req = 1'b0;
        step();
        chk(!in_self && ras_n && cas_n && own, "R9 exit raises strobes", int'(in_self), 0);
        ex = 0;
        while (own && ras_n && ex < 1000) begin ex++; step(); end
        chk_eq("R9 exit hold cycles", ex, P_EXIT);
        chk_eq("R9 ready after exit", int'(ready), 1);
        quiet = 0;
        repeat (P_INT - 2) begin
            step();
            if (req) quiet++;
        end
        chk_eq("R9 no catch-up request", quiet, 0);
        n = 0;
        repeat (5) begin step(); if (req) n++; end
        chk(n > 0, "R9 pacing resumes after one period", n, 1);

        // R11: burst policy instance
        sr_req_b = 1'b1;
        for (int g = 0; g < 2000 && !in_self_b; g++) step();
        chk_eq("R11 burst instance in self refresh", int'(in_self_b), 1);
        sr_req_b = 1'b0;
        for (int g = 0; g < 100 && own_b; g++) step();
        chk_eq("R11 ready held low after exit", int'(ready_b), 0);
        n = 0; prev = ras_b;
        for (int g = 0; g < 2000 && !ready_b; g++) begin
            step();
            if (prev && !ras_b) n++;
            prev = ras_b;
        end
        chk_eq("R11 burst refresh count", n, P_BROWS);

        repeat (5) step();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule